// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Flag Register

This block is the arithmetic and logic unit of a small 8-bit accumulator machine. Each operation takes a destination operand (the current value of the register being written), a source operand (a second register or an immediate byte), a 5-bit operation code, and the present carry and zero flags. It returns the result, a write enable for the destination register, and the new flags. The result and the write enable are combinational and valid in the same cycle as the operands. The flags pass through a register and appear one cycle later.

The operations are plain and carry-gated increment and decrement, add and subtract with and without carry, clear, the bitwise operations, nibble swap, one-bit shifts, compare and move. The carry-gated forms read the incoming carry flag as an inverted or a direct adjustment:
- Add-with-carry and conditional increment add an extra one while carry is clear.
- Subtract-with-carry and conditional decrement take away an extra one while carry is set.

Operations enter on a valid strobe. The block has no ready signal, so it accepts one operation every cycle and never applies back-pressure. `out_valid` marks the cycle in which the registered flags from that operation become visible. Instruction sequencing and register storage sit outside the block.

Top module: `alu8_core`

## Requirements
- R1: Operation codes are MOV=0, CLR=1, NOT=2, AND=3, OR=4, XOR=5, INC=6, INCC=7, DEC=8, DECC=9, ADD=10, ADDC=11, SUB=12, SUBC=13, SWAP=14, SHL=15, SHR=16, CMP=17. Codes 18 to 31 deassert `write_en` and keep the flags equal to `carry_in`/`zero_in`.
- R2: INC gives dst+1 and DEC gives dst-1. ADD gives dst+src and SUB gives dst-src. All are modulo 256. Carry is the carry out of bit 7 for INC and ADD, and the borrow for DEC and SUB.
- R3: INCC gives dst+1 when `carry_in`=0 and dst when `carry_in`=1. DECC gives dst-1 when `carry_in`=1 and dst when `carry_in`=0. Carry is the carry out (INCC) or the borrow (DECC) of that adjusted operation.
- R4: ADDC gives dst+src+1 when `carry_in`=0 and dst+src when `carry_in`=1. SUBC gives dst-src-1 when `carry_in`=1 and dst-src when `carry_in`=0. Carry is the carry out or borrow of the complete operation.
- R5: CLR gives 0. NOT gives ~dst. AND, OR and XOR combine dst with src bitwise. All five clear the carry flag.
- R6: SWAP gives {dst[3:0], dst[7:4]} and clears the carry flag.
- R7: SHL gives {dst[6:0],0} with carry = dst[7]. SHR gives {0,dst[7:1]} with carry = dst[0].
- R8: CMP never asserts `write_en`. It sets carry when dst < src (unsigned) and sets zero when dst == src.
- R9: For every operation other than MOV and the unused codes, the zero flag is set exactly when the 8-bit result is zero.
- R10: MOV gives src, asserts `write_en`, and loads the flags with `carry_in`/`zero_in` unchanged.
- R11: `result` and `write_en` follow the inputs in the same cycle. With `in_valid`=1, `carry_q`/`zero_q` take the new flags and `out_valid` rises at the next clock edge. With `in_valid`=0, `out_valid` is 0 at the next edge and the flags keep their value.
- R12: While `rst_n` is low, `carry_q`, `zero_q` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation select (R1) |
| dst_val | input | 8 | Destination operand (bus A) |
| src_val | input | 8 | Source operand or immediate (bus B) |
| carry_in | input | 1 | Current carry flag |
| zero_in | input | 1 | Current zero flag |
| result | output | 8 | Combinational result |
| write_en | output | 1 | Destination should take `result` |
| out_valid | output | 1 | Registered flags belong to the previous operation |
| carry_q | output | 1 | Registered carry flag |
| zero_q | output | 1 | Registered zero flag |

## Verification
The hardest cases to reach are the carry-gated operations at their wrap points. An example is a conditional decrement of zero: it must produce 0xFF with borrow when carry is set, but leave zero and clear carry when carry is clear. Further examples are add-with-carry where the extra one alone causes the overflow, and subtract-with-carry of equal operands. A directed vector table places each of these on both carry states. A sweep then runs every operation code under all four carry/zero input pairs with random operands, against a bench model of the requirements. A final directed test holds `in_valid` low after a flag-setting operation to show that the flags do not change.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_MOV  = 5'd0,
    OP_CLR  = 5'd1,
    OP_NOT  = 5'd2,
    OP_AND  = 5'd3,
    OP_OR   = 5'd4,
    OP_XOR  = 5'd5,
    OP_INC  = 5'd6,
    OP_INCC = 5'd7,
    OP_DEC  = 5'd8,
    OP_DECC = 5'd9,
    OP_ADD  = 5'd10,
    OP_ADDC = 5'd11,
    OP_SUB  = 5'd12,
    OP_SUBC = 5'd13,
    OP_SWAP = 5'd14,
    OP_SHL  = 5'd15,
    OP_SHR  = 5'd16,
    OP_CMP  = 5'd17
  } alu_op_e;

  // Control word produced by the decoder for one operation.
  typedef struct packed {
    logic use_arith;   // result taken from the adder/subtractor
    logic subtract;    // adder runs as subtractor
    logic zero_rhs;    // adder right-hand operand forced to zero
    logic extra;       // extra one added or borrowed
    logic writes;      // destination update
    logic sets_flags;  // flags take computed values
  } alu_ctrl_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  input  logic             subtract,
  input  logic             extra,
  output logic [WIDTH-1:0] value,
  output logic             cout
);
  localparam int EW = WIDTH + 1;

  logic [EW-1:0] wide;

  // One extended-width adder/subtractor; the top bit is carry or borrow.
  always_comb begin
    if (subtract)
      wide = {1'b0, lhs} - {1'b0, rhs} - EW'(extra);
    else
      wide = {1'b0, lhs} + {1'b0, rhs} + EW'(extra);
  end

  assign value = wide[WIDTH-1:0];
  assign cout  = wide[WIDTH];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output logic [WIDTH-1:0] value,
  output logic             cout
);
  localparam int HALF = WIDTH / 2;

  logic [WIDTH-1:0] swapped;

  // Half-word exchange built bit by bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_swap
    if (i < HALF) begin : g_lo
      assign swapped[i] = lhs[i + HALF];
    end else begin : g_hi
      assign swapped[i] = lhs[i - HALF];
    end
  end

  always_comb begin
    value = '0;
    cout  = 1'b0;
    case (op)
      OP_CLR:  value = '0;
      OP_NOT:  value = ~lhs;
      OP_AND:  value = lhs & rhs;
      OP_OR:   value = lhs | rhs;
      OP_XOR:  value = lhs ^ rhs;
      OP_SWAP: value = swapped;
      OP_SHL: begin
        value = {lhs[WIDTH-2:0], 1'b0};
        cout  = lhs[WIDTH-1];
      end
      OP_SHR: begin
        value = {1'b0, lhs[WIDTH-1:1]};
        cout  = lhs[0];
      end
      default: begin
        value = '0;
        cout  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic c_d,
  input  logic z_d,
  output logic c_q,
  output logic z_q,
  output logic valid_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_q     <= 1'b0;
      z_q     <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= load;
      if (load) begin
        c_q <= c_d;
        z_q <= z_d;
      end
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [4:0]       op_code,
  input  logic [WIDTH-1:0] dst_val,
  input  logic [WIDTH-1:0] src_val,
  input  logic             carry_in,
  input  logic             zero_in,
  output logic [WIDTH-1:0] result,
  output logic             write_en,
  output logic             out_valid,
  output logic             carry_q,
  output logic             zero_q
);
  alu_op_e          op;
  alu_ctrl_t        ctl;
  logic [WIDTH-1:0] arith_rhs;
  logic [WIDTH-1:0] arith_val;
  logic             arith_cout;
  logic [WIDTH-1:0] logic_val;
  logic             logic_cout;
  logic             c_next;
  logic             z_next;

  assign op = alu_op_e'(op_code);

  // Decoder: every arithmetic form maps onto one adder with an extra bit.
  always_comb begin
    ctl = '0;
    case (op)
      OP_MOV:  ctl = '{use_arith: 1'b0, subtract: 1'b0, zero_rhs: 1'b0,
                       extra: 1'b0, writes: 1'b1, sets_flags: 1'b0};
      OP_CLR, OP_NOT, OP_AND, OP_OR, OP_XOR, OP_SWAP, OP_SHL, OP_SHR:
               ctl = '{use_arith: 1'b0, subtract: 1'b0, zero_rhs: 1'b0,
                       extra: 1'b0, writes: 1'b1, sets_flags: 1'b1};
      OP_INC:  ctl = '{use_arith: 1'b1, subtract: 1'b0, zero_rhs: 1'b1,
                       extra: 1'b1, writes: 1'b1, sets_flags: 1'b1};
      OP_INCC: ctl = '{use_arith: 1'b1, subtract: 1'b0, zero_rhs: 1'b1,
                       extra: ~carry_in, writes: 1'b1, sets_flags: 1'b1};
      OP_DEC:  ctl = '{use_arith: 1'b1, subtract: 1'b1, zero_rhs: 1'b1,
                       extra: 1'b1, writes: 1'b1, sets_flags: 1'b1};
      OP_DECC: ctl = '{use_arith: 1'b1, subtract: 1'b1, zero_rhs: 1'b1,
                       extra: carry_in, writes: 1'b1, sets_flags: 1'b1};
      OP_ADD:  ctl = '{use_arith: 1'b1, subtract: 1'b0, zero_rhs: 1'b0,
                       extra: 1'b0, writes: 1'b1, sets_flags: 1'b1};
      OP_ADDC: ctl = '{use_arith: 1'b1, subtract: 1'b0, zero_rhs: 1'b0,
                       extra: ~carry_in, writes: 1'b1, sets_flags: 1'b1};
      OP_SUB:  ctl = '{use_arith: 1'b1, subtract: 1'b1, zero_rhs: 1'b0,
                       extra: 1'b0, writes: 1'b1, sets_flags: 1'b1};
      OP_SUBC: ctl = '{use_arith: 1'b1, subtract: 1'b1, zero_rhs: 1'b0,
                       extra: carry_in, writes: 1'b1, sets_flags: 1'b1};
      OP_CMP:  ctl = '{use_arith: 1'b1, subtract: 1'b1, zero_rhs: 1'b0,
                       extra: 1'b0, writes: 1'b0, sets_flags: 1'b1};
      default: ctl = '0;
    endcase
  end

  assign arith_rhs = ctl.zero_rhs ? '0 : src_val;

  alu8_arith #(.WIDTH(WIDTH)) u_arith (
    .lhs      (dst_val),
    .rhs      (arith_rhs),
    .subtract (ctl.subtract),
    .extra    (ctl.extra),
    .value    (arith_val),
    .cout     (arith_cout)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .op    (op),
    .lhs   (dst_val),
    .rhs   (src_val),
    .value (logic_val),
    .cout  (logic_cout)
  );

  // Result select and flag computation.
  always_comb begin
    if (op == OP_MOV)
      result = src_val;
    else if (ctl.use_arith)
      result = arith_val;
    else
      result = logic_val;
  end

  assign write_en = ctl.writes;

  always_comb begin
    if (ctl.sets_flags) begin
      c_next = ctl.use_arith ? arith_cout : logic_cout;
      z_next = (result == '0);
    end else begin
      c_next = carry_in;
      z_next = zero_in;
    end
  end

  alu8_flags u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (in_valid),
    .c_d     (c_next),
    .z_d     (z_next),
    .c_q     (carry_q),
    .z_q     (zero_q),
    .valid_q (out_valid)
  );
endmodule

// File: rtl/alu8_core_checker.sv
module alu8_core_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [4:0] op_code,
  input logic       carry_in,
  input logic       zero_in,
  input logic [7:0] result,
  input logic       write_en,
  input logic       out_valid,
  input logic       carry_q,
  input logic       zero_q
);
  assert_cmp_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 5'd17) |-> !write_en);

  assert_unused_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code > 5'd17) |-> !write_en);

  assert_move_keeps_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 5'd0) |=>
      (carry_q == $past(carry_in) && zero_q == $past(zero_in)));

  assert_logic_clears_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code >= 5'd1 && op_code <= 5'd5) |=> !carry_q);

  assert_swap_clears_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_code == 5'd14) |=> !carry_q);

  assert_zero_tracks_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && write_en && op_code != 5'd0) |=> (zero_q == ($past(result) == 8'd0)));

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(carry_q) && $stable(zero_q)));
endmodule

bind alu8_core alu8_core_checker u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_code   (op_code),
  .carry_in  (carry_in),
  .zero_in   (zero_in),
  .result    (result),
  .write_en  (write_en),
  .out_valid (out_valid),
  .carry_q   (carry_q),
  .zero_q    (zero_q)
);

// File: tb/alu8_core_test.sv
`timescale 1ns/1ps
module alu8_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] dst_val = '0;
  logic [7:0] src_val = '0;
  logic       carry_in = 1'b0;
  logic       zero_in = 1'b0;
  logic [7:0] result;
  logic       write_en;
  logic       out_valid;
  logic       carry_q;
  logic       zero_q;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  alu8_core uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .dst_val(dst_val), .src_val(src_val), .carry_in(carry_in), .zero_in(zero_in),
    .result(result), .write_en(write_en), .out_valid(out_valid),
    .carry_q(carry_q), .zero_q(zero_q)
  );

  typedef struct packed {
    logic [3:0] req;
    logic [4:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic       ci;
    logic       zi;
    logic [7:0] res;
    logic       we;
    logic       co;
    logic       zo;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  5'd10, 8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 1'b1, 1'b0, 1'b0}, // R2 add
    '{4'd2,  5'd10, 8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1}, // R2 add wrap
    '{4'd4,  5'd11, 8'h10, 8'h20, 1'b0, 1'b0, 8'h31, 1'b1, 1'b0, 1'b0}, // R4 addc c=0
    '{4'd4,  5'd11, 8'h10, 8'h20, 1'b1, 1'b0, 8'h30, 1'b1, 1'b0, 1'b0}, // R4 addc c=1
    '{4'd4,  5'd11, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1}, // R4 extra one wraps
    '{4'd2,  5'd12, 8'h05, 8'h07, 1'b0, 1'b0, 8'hFE, 1'b1, 1'b1, 1'b0}, // R2 sub borrow
    '{4'd4,  5'd13, 8'h05, 8'h05, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0}, // R4 subc c=1
    '{4'd4,  5'd13, 8'h05, 8'h05, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1}, // R4 subc c=0
    '{4'd3,  5'd7,  8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1}, // R3 incc c=0
    '{4'd3,  5'd7,  8'h41, 8'h00, 1'b1, 1'b1, 8'h41, 1'b1, 1'b0, 1'b0}, // R3 incc c=1
    '{4'd3,  5'd9,  8'h00, 8'h00, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1, 1'b0}, // R3 decc c=1
    '{4'd3,  5'd9,  8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1}, // R3 decc c=0
    '{4'd6,  5'd14, 8'hA5, 8'h00, 1'b1, 1'b1, 8'h5A, 1'b1, 1'b0, 1'b0}, // R6 swap
    '{4'd7,  5'd15, 8'h81, 8'h00, 1'b0, 1'b0, 8'h02, 1'b1, 1'b1, 1'b0}, // R7 shl
    '{4'd7,  5'd16, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1}, // R7 shr
    '{4'd7,  5'd16, 8'h80, 8'h00, 1'b1, 1'b0, 8'h40, 1'b1, 1'b0, 1'b0}, // R7 shr no carry
    '{4'd8,  5'd17, 8'h30, 8'h30, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R8 cmp equal
    '{4'd8,  5'd17, 8'h10, 8'h20, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0}, // R8 cmp less
    '{4'd10, 5'd0,  8'h12, 8'h99, 1'b1, 1'b1, 8'h99, 1'b1, 1'b1, 1'b1}, // R10 mov
    '{4'd10, 5'd0,  8'h12, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0}, // R10 mov zero value
    '{4'd5,  5'd1,  8'h55, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1}, // R5 clr
    '{4'd5,  5'd2,  8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1}, // R5 not
    '{4'd5,  5'd3,  8'hF0, 8'h3C, 1'b1, 1'b1, 8'h30, 1'b1, 1'b0, 1'b0}, // R5 and
    '{4'd5,  5'd4,  8'hF0, 8'h0C, 1'b1, 1'b0, 8'hFC, 1'b1, 1'b0, 1'b0}, // R5 or
    '{4'd9,  5'd5,  8'hAA, 8'hAA, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1}, // R9 xor zero
    '{4'd2,  5'd6,  8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1}, // R2 inc wrap
    '{4'd2,  5'd8,  8'h00, 8'h00, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b1, 1'b0}, // R2 dec wrap
    '{4'd1,  5'd31, 8'h44, 8'h11, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0}  // R1 unused code
  };

  typedef struct packed {
    logic [7:0] res;
    logic       we;
    logic       c;
    logic       z;
  } exp_t;

  // Reference model written from the requirement list.
  function automatic exp_t model(input logic [4:0] op, input logic [7:0] a,
                                 input logic [7:0] b, input logic ci, input logic zi);
    exp_t e;
    logic [8:0] w;
    logic flags;
    e = '0;
    e.we = 1'b1;
    flags = 1'b1;
    w = '0;
    case (op)
      5'd0:  begin e.res = b; flags = 1'b0; end
      5'd1:  e.res = 8'h00;
      5'd2:  e.res = ~a;
      5'd3:  e.res = a & b;
      5'd4:  e.res = a | b;
      5'd5:  e.res = a ^ b;
      5'd6:  begin w = {1'b0, a} + 9'd1; {e.c, e.res} = w; end
      5'd7:  begin w = {1'b0, a} + (ci ? 9'd0 : 9'd1); {e.c, e.res} = w; end
      5'd8:  begin w = {1'b0, a} - 9'd1; {e.c, e.res} = w; end
      5'd9:  begin w = {1'b0, a} - (ci ? 9'd1 : 9'd0); {e.c, e.res} = w; end
      5'd10: begin w = {1'b0, a} + {1'b0, b}; {e.c, e.res} = w; end
      5'd11: begin w = {1'b0, a} + {1'b0, b} + (ci ? 9'd0 : 9'd1); {e.c, e.res} = w; end
      5'd12: begin w = {1'b0, a} - {1'b0, b}; {e.c, e.res} = w; end
      5'd13: begin w = {1'b0, a} - {1'b0, b} - (ci ? 9'd1 : 9'd0); {e.c, e.res} = w; end
      5'd14: e.res = {a[3:0], a[7:4]};
      5'd15: begin e.res = {a[6:0], 1'b0}; e.c = a[7]; end
      5'd16: begin e.res = {1'b0, a[7:1]}; e.c = a[0]; end
      5'd17: begin e.we = 1'b0; e.c = (a < b); e.res = a - b; end
      default: begin e.we = 1'b0; flags = 1'b0; end
    endcase
    if (flags) e.z = (e.res == 8'h00);
    else begin e.c = ci; e.z = zi; end
    return e;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Drive one operation at the falling edge and check both stages.
  task automatic run_op(input int req, input logic [4:0] op, input logic [7:0] a,
                        input logic [7:0] b, input logic ci, input logic zi,
                        input exp_t e);
    string tag;
    tag = $sformatf("R%0d op=%0d a=%h b=%h c=%0b z=%0b", req, op, a, b, ci, zi);
    @(negedge clk);
    in_valid = 1'b1; op_code = op; dst_val = a; src_val = b;
    carry_in = ci; zero_in = zi;
    #1;
    check({tag, " write_en"}, {7'd0, write_en}, {7'd0, e.we});
    if (e.we) check({tag, " result"}, result, e.res);
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " carry (R11 timing)"}, {7'd0, carry_q}, {7'd0, e.c});
    check({tag, " zero (R11 timing)"}, {7'd0, zero_q}, {7'd0, e.z});
    check({tag, " out_valid R11"}, {7'd0, out_valid}, 8'd1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    exp_t e;
    // R12: reset state
    repeat (3) @(negedge clk);
    check("R12 carry_q in reset", {7'd0, carry_q}, 8'd0);
    check("R12 zero_q in reset", {7'd0, zero_q}, 8'd0);
    check("R12 out_valid in reset", {7'd0, out_valid}, 8'd0);
    rst_n = 1'b1;

    // Directed vector table.
    for (int i = 0; i < NV; i++) begin
      e = '{res: VECS[i].res, we: VECS[i].we, c: VECS[i].co, z: VECS[i].zo};
      run_op(int'(VECS[i].req), VECS[i].op, VECS[i].a, VECS[i].b,
             VECS[i].ci, VECS[i].zi, e);
    end

    // Sweep: every code across the four carry/zero input pairs (R1..R10).
    for (int op = 0; op < 32; op++) begin
      for (int cz = 0; cz < 4; cz++) begin
        for (int k = 0; k < 3; k++) begin
          logic [7:0] a;
          logic [7:0] b;
          a = 8'($urandom);
          b = (k == 0) ? a : 8'($urandom);
          e = model(5'(op), a, b, cz[1], cz[0]);
          run_op(9, 5'(op), a, b, cz[1], cz[0], e);
        end
      end
    end

    // R11: idle cycles keep flags after a carry-setting operation.
    e = model(5'd10, 8'hFF, 8'hFF, 1'b0, 1'b0);
    run_op(11, 5'd10, 8'hFF, 8'hFF, 1'b0, 1'b0, e);
    carry_in = 1'b0; zero_in = 1'b1; op_code = 5'd1; dst_val = 8'h00;
    repeat (3) @(negedge clk);
    check("R11 idle carry hold", {7'd0, carry_q}, 8'd1);
    check("R11 idle zero hold", {7'd0, zero_q}, 8'd0);
    check("R11 idle out_valid", {7'd0, out_valid}, 8'd0);

    // R12: reset mid-run clears the flags again.
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 carry_q after reset", {7'd0, carry_q}, 8'd0);
    check("R12 out_valid after reset", {7'd0, out_valid}, 8'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule